// File: doc/BRIEF.md
# Shared-Timer Input Debounce Unit

The unit cleans up a bank of asynchronous input pins before the rest of the chip looks at them. Every pin first goes through a synchronizer. It is then either passed on unfiltered, or held at its last accepted level until the synchronized input has kept a new level for a programmed number of clock cycles. The number of cycles comes from a small pool of three period registers. Any number of pins can refer to the same period register. Each pin keeps its own stability counter, so pins that share a period still filter on their own.

Software programs the unit through a plain single-cycle configuration port. A write happens in any cycle in which `cfg_wr` is high. Reads are combinational from `cfg_addr`. The port never stalls, so there is no back-pressure and no handshake. The filtered pin vector is a plain level output with no valid or ready qualifier, and it is meaningful in every cycle.

Top module: `dbnc_shared_timer`

## Requirements
- R1: After reset, every configuration register reads 0, every pin is in pass-through mode, and `pin_out` is 0.
- R2: Configuration word addresses are: 0 = upper select bits, 1 = lower select bits, 2/3/4 = period of timer 1/2/3 (a cycle count). Each of these reads back the last value written. Addresses 5 to 7 read 0, and a write to them changes no register.
- R3: The select code of pin n is {word0[n], word1[n]}. Code 0 means pass-through, and codes 1, 2 and 3 use the periods of timers 1, 2 and 3. Changing a pin from pass-through to filtered while its input is steady leaves `pin_out` unchanged.
- R4: A pass-through pin shows a change of `pin_raw` on `pin_out` after exactly 2 clock edges (the synchronizer depth), with no further delay.
- R5: For a filtered pin with period P ≥ 1, a level change on `pin_raw` that is held steady appears on `pin_out` exactly P+2 edges after the change.
- R6: If the synchronized input of a filtered pin returns to the accepted level before P cycles have passed, the change is dropped and the pin's counter starts again from zero.
- R7: Several pins that select the same timer each filter with that timer's period, independently of one another.
- R8: A period value of 0 behaves as a period of 1.
- R9: A write that changes a pin's select code, or any write to the period register of the timer the pin uses, restarts that pin's counter at the write edge. The pin then needs a full period after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 3 | Configuration word address |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data for `cfg_addr` |
| pin_raw | input | NPIN (32) | Asynchronous raw pin levels |
| pin_out | output | NPIN (32) | Debounced pin levels |

## Verification
The hardest case to reach is a configuration write that lands while a pin is part-way through counting. The restart rule cannot be seen unless the write arrives after some cycles of counting and before the count completes. The stimulus therefore changes a pin, waits a fixed number of edges, and then rewrites the period of the pin's timer with the same value, or moves the pin to another timer with an equal period. The expected flip is predicted one full period after the write edge, and the design is also checked at the edge where it would have flipped had the counter not restarted.

// File: rtl/dbnc_pkg.sv
`timescale 1ns/1ps
package dbnc_pkg;
  // number of shared period timers; a 2-bit select addresses them plus bypass
  localparam int unsigned TMR_N = 3;
  localparam int unsigned SEL_W = 2;
  localparam int unsigned AW    = 3;

  localparam logic [AW-1:0] ADR_SEL_HI   = 3'd0;
  localparam logic [AW-1:0] ADR_SEL_LO   = 3'd1;
  localparam logic [AW-1:0] ADR_TMR_BASE = 3'd2;
endpackage

// File: rtl/dbnc_sync.sv
`timescale 1ns/1ps
module dbnc_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else if (s == 0) chain_q[s] <= d_i;
      else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dbnc_regs.sv
`timescale 1ns/1ps
module dbnc_regs
  import dbnc_pkg::*;
#(
  parameter int NPIN  = 32,
  parameter int CNT_W = 32,
  parameter int DW    = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [AW-1:0]                     addr,
  input  logic [DW-1:0]                     wdata,
  output logic [DW-1:0]                     rdata,
  output logic [NPIN-1:0][SEL_W-1:0]        sel_o,
  output logic [TMR_N-1:0][CNT_W-1:0]       period_o,
  output logic [NPIN-1:0]                   restart_o
);
  logic [NPIN-1:0] hi_q, lo_q, hi_n, lo_n;
  logic [TMR_N-1:0][CNT_W-1:0] per_q;
  logic [TMR_N-1:0] tmr_wr;

  // next-state of the select words and per-timer write strobes
  always_comb begin
    hi_n   = hi_q;
    lo_n   = lo_q;
    tmr_wr = '0;
    if (wr_en) begin
      if (addr == ADR_SEL_HI) hi_n = wdata[NPIN-1:0];
      if (addr == ADR_SEL_LO) lo_n = wdata[NPIN-1:0];
      for (int k = 0; k < TMR_N; k++) begin
        if (addr == ADR_TMR_BASE + AW'(k)) tmr_wr[k] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      per_q <= '0;
    end else begin
      hi_q <= hi_n;
      lo_q <= lo_n;
      for (int k = 0; k < TMR_N; k++) begin
        if (tmr_wr[k]) per_q[k] <= wdata[CNT_W-1:0];
      end
    end
  end

  // per-pin select assembly and restart request
  for (genvar gi = 0; gi < NPIN; gi++) begin : g_pin
    logic [SEL_W-1:0] cur_sel, nxt_sel;
    assign cur_sel = {hi_q[gi], lo_q[gi]};
    assign nxt_sel = {hi_n[gi], lo_n[gi]};
    assign sel_o[gi] = cur_sel;
    assign restart_o[gi] = (nxt_sel != cur_sel) ||
                           ((cur_sel != '0) && tmr_wr[cur_sel - SEL_W'(1)]);
  end

  assign period_o = per_q;

  always_comb begin
    rdata = '0;
    if (addr == ADR_SEL_HI) rdata[NPIN-1:0] = hi_q;
    if (addr == ADR_SEL_LO) rdata[NPIN-1:0] = lo_q;
    for (int k = 0; k < TMR_N; k++) begin
      if (addr == ADR_TMR_BASE + AW'(k)) rdata[CNT_W-1:0] = per_q[k];
    end
  end

  // R2
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr > ADR_TMR_BASE + AW'(TMR_N - 1)))
      |=> ($stable(hi_q) && $stable(lo_q) && $stable(per_q)));
endmodule

// File: rtl/dbnc_pin.sv
`timescale 1ns/1ps
module dbnc_pin
  import dbnc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             restart_i,
  output logic             pin_o
);
  logic             filt_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] eff;
  logic             bypass;
  logic             done;

  assign bypass = (sel_i == '0);
  // a zero period is treated as a single-cycle filter
  assign eff    = (period_i == '0) ? CNT_W'(1) : period_i;
  assign done   = ({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, eff};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (bypass) begin
      filt_q <= sync_i;
      cnt_q  <= '0;
    end else if (restart_i || (sync_i == filt_q)) begin
      cnt_q  <= '0;
    end else if (done) begin
      filt_q <= sync_i;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  assign pin_o = bypass ? sync_i : filt_q;

  // R5
  hold_when_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && (sync_i == filt_q)) |=> $stable(filt_q));

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < eff);

  // R9
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt_q == '0));
endmodule

// File: rtl/dbnc_shared_timer.sv
`timescale 1ns/1ps
module dbnc_shared_timer
  import dbnc_pkg::*;
#(
  parameter int NPIN        = 32,
  parameter int CNT_W       = 32,
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [DW-1:0]   cfg_wdata,
  output logic [DW-1:0]   cfg_rdata,
  input  logic [NPIN-1:0] pin_raw,
  output logic [NPIN-1:0] pin_out
);
  logic [NPIN-1:0]                 sync_v;
  logic [NPIN-1:0][SEL_W-1:0]      sel_v;
  logic [TMR_N-1:0][CNT_W-1:0]     period_v;
  logic [NPIN-1:0]                 restart_v;

  dbnc_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_raw),
    .q_o   (sync_v)
  );

  dbnc_regs #(.NPIN(NPIN), .CNT_W(CNT_W), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .rdata     (cfg_rdata),
    .sel_o     (sel_v),
    .period_o  (period_v),
    .restart_o (restart_v)
  );

  for (genvar gi = 0; gi < NPIN; gi++) begin : g_lane
    logic [CNT_W-1:0] per_pick;
    assign per_pick = (sel_v[gi] == '0) ? '0 : period_v[sel_v[gi] - SEL_W'(1)];

    dbnc_pin #(.CNT_W(CNT_W)) u_pin (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_i    (sync_v[gi]),
      .sel_i     (sel_v[gi]),
      .period_i  (per_pick),
      .restart_i (restart_v[gi]),
      .pin_o     (pin_out[gi])
    );
  end
endmodule

// File: tb/dbnc_shared_timer_tb.sv
`timescale 1ns/1ps
module dbnc_shared_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [31:0] pin_raw;
  logic [31:0] pin_out;

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  dbnc_shared_timer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .pin_raw   (pin_raw),
    .pin_out   (pin_out)
  );

  typedef struct {
    int          at;
    logic [31:0] mask;
    logic [31:0] val;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  exp_t mon_e;
  int   total = 0;
  int   bad   = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // driver side: queue an expectation 'd' edges from now
  task automatic expect_in(int d, logic [31:0] mask, logic [31:0] val, string tag);
    sb_q.push_back('{cyc + d, mask, val, tag});
  endtask

  // monitor: compare queued expectations when their cycle comes up
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
      mon_e = sb_q.pop_front();
      if (mon_e.at < cyc) chk({mon_e.tag, " missed"}, 32'h0, 32'h1);
      else chk(mon_e.tag, pin_out & mon_e.mask, mon_e.val & mon_e.mask);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    cfg_wr    = 1'b1;
    cfg_addr  = a;
    cfg_wdata = d;
    @(negedge clk);
    cfg_wr    = 1'b0;
  endtask

  task automatic rd_chk(logic [2:0] a, logic [31:0] exp, string tag);
    cfg_addr = a;
    #1;
    chk(tag, cfg_rdata, exp);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0; pin_raw = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 pin_out", pin_out, 32'h0);
    for (int a = 0; a < 5; a++) rd_chk(3'(a), 32'h0, "R1 reg");

    // R4 pass-through latency of two edges
    pin_raw = 32'hFFFF_FFFF;
    expect_in(1, 32'hFFFF_FFFF, 32'h0, "R4 before sync");
    expect_in(2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4 after sync");
    idle(3);

    // program: pins 0-7 timer1, 8-15 timer2, 16-23 timer3, 24-31 bypass
    wr(3'd2, 32'd5);
    wr(3'd3, 32'd5);
    wr(3'd4, 32'd0);
    wr(3'd0, 32'h00FF_FF00);
    wr(3'd1, 32'h00FF_00FF);
    idle(2);
    rd_chk(3'd0, 32'h00FF_FF00, "R2 sel hi");
    rd_chk(3'd1, 32'h00FF_00FF, "R2 sel lo");
    rd_chk(3'd2, 32'd5, "R2 timer1");
    rd_chk(3'd3, 32'd5, "R2 timer2");
    rd_chk(3'd4, 32'd0, "R2 timer3");
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rd_chk(3'd5, 32'h0, "R2 unmapped read");
    rd_chk(3'd7, 32'h0, "R2 unmapped read");
    rd_chk(3'd0, 32'h00FF_FF00, "R2 sel hi after unmapped write");
    rd_chk(3'd2, 32'd5, "R2 timer1 after unmapped write");
    chk("R3 no glitch on select change", pin_out, 32'hFFFF_FFFF);

    // R5 R7 R8 R4: drop all pins at once
    pin_raw = 32'h0;
    expect_in(2, 32'hFF00_0000, 32'h0, "R4 bypass pins");
    expect_in(2, 32'h00FF_0000, 32'h00FF_0000, "R8 zero period before");
    expect_in(3, 32'h00FF_0000, 32'h0, "R8 zero period acts as one");
    expect_in(6, 32'h0000_FFFF, 32'h0000_FFFF, "R5 R7 shared period not yet");
    expect_in(7, 32'h0000_FFFF, 32'h0, "R5 R7 shared period reached");
    idle(8);

    // R6 short pulse rejected
    pin_raw = 32'h0000_00FF;
    idle(3);
    pin_raw = 32'h0;
    expect_in(4, 32'h0000_00FF, 32'h0, "R6 pulse rejected");
    expect_in(6, 32'h0000_00FF, 32'h0, "R6 pulse rejected later");
    idle(7);
    pin_raw = 32'h0000_00FF;
    expect_in(6, 32'h0000_00FF, 32'h0, "R6 fresh count not done");
    expect_in(7, 32'h0000_00FF, 32'h0000_00FF, "R5 fresh count done");
    idle(8);

    // R9 rewrite of the pin's timer restarts its count
    pin_raw = 32'h0;
    expect_in(7, 32'h0000_00FF, 32'h0000_00FF, "R9 timer write restart");
    expect_in(10, 32'h0000_00FF, 32'h0000_00FF, "R9 timer write restart");
    expect_in(11, 32'h0000_00FF, 32'h0, "R9 timer write full period");
    idle(5);
    wr(3'd2, 32'd5);
    idle(6);

    // R9 select change restarts: move pins 0-7 from timer1 to timer3
    wr(3'd4, 32'd5);
    idle(2);
    pin_raw = 32'h0000_00FF;
    expect_in(7, 32'h0000_00FF, 32'h0, "R9 select change restart");
    expect_in(10, 32'h0000_00FF, 32'h0, "R9 select change restart");
    expect_in(11, 32'h0000_00FF, 32'h0000_00FF, "R9 R3 select change full period");
    idle(5);
    wr(3'd0, 32'h00FF_FFFF);
    idle(6);
    rd_chk(3'd0, 32'h00FF_FFFF, "R2 sel hi final");

    idle(3);
    if (sb_q.size() != 0) chk("scoreboard drain", 32'(sb_q.size()), 32'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule